// File: doc/BRIEF.md
# Full-Period Linear Feedback Counter

This block is a right-shifting XOR feedback shift register that steps through every one of its 2^n states, including the all-zeros state, exactly once per period. A plain maximal-length register of this kind has one dead state, all zeros, and can never reach it. If an upset forces the register into that state, it stays there. Here, an extra term detects the state in which every bit above bit 0 is zero. That term is folded into the feedback, so the register passes through all zeros once and then leaves it again.

The register width is a parameter, and each supported width selects one fixed tap set. The supported widths are 3 to 8, 16 and 32. Widths 8, 16 and 32 use four taps and the rest use two. Typical uses are pattern sources, cheap long-period counters and built-in self-test stimulus. The parallel state is the output. A clock enable gates every update, and an active-low synchronous reset loads all ones.

Top module: `full_period_lfsr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is all ones, whatever `en` is.
- R2: With `rst_n` high and `en` low, the state does not change.
- R3: On each enabled step, bit i of the new state equals bit i+1 of the old state, for i from 0 to WIDTH-2.
- R4: On an enabled step where some bit above bit 0 is one, the new top bit is the XOR of the tap bits. At width 4 the taps are bits 1 and 0. At width 8 they are bits 4, 3, 2 and 0.
- R5: On an enabled step from the state 0…01, the next state is all zeros.
- R6: On an enabled step from all zeros, the next state is 10…0, with only the top bit set.
- R7: Starting from all ones, 2^WIDTH enabled steps return the register to all ones, and every state appears exactly once along the way. This is checked at widths 4 and 8.
- R8: At width 4, after reset the states run 15, 7, 3, 1, 0, 8, 4, 2, 9, 12, 6, 11, 5, 10, 13, 14 (in hex F,7,3,1,0,8,4,2,9,C,6,B,5,A,D,E) and then return to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; loads all ones |
| en | input | 1 | Step enable; when low the state is held |
| state_q | output | WIDTH | Current register state |

## Verification
The zero-splice path and the enable gate can act in the same cycle. This happens when the register sits at 0…01 or at all zeros and `en` is low. The bench steers the register to the near-zero state, holds `en` low for several cycles, and then releases it. It does the same at all zeros. It expects the state to stay frozen while `en` is low, and to take exactly one splice step once `en` returns. A second collision is reset arriving together with `en` high. There, the expected state is all ones, not the next sequence value.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  // Feedback tap mask for a right-shifting register; bit k set means state bit k
  // is XORed into the bit that enters at the top. Zero for an unsupported width.
  function automatic logic [63:0] tap_mask(input int width);
    logic [63:0] m;
    case (width)
      3, 4, 6, 7: m = 64'h3;
      5:          m = 64'h5;
      8:          m = 64'h1D;
      16:         m = 64'h100B;
      32:         m = 64'hC000_0401;
      default:    m = 64'h0;
    endcase
    return m;
  endfunction

  // Number of taps in a mask, for documentation and checks.
  function automatic int tap_count(input logic [63:0] m);
    int c;
    c = 0;
    for (int k = 0; k < 64; k++) c += int'(m[k]);
    return c;
  endfunction

endpackage

// File: rtl/lfsr_tap_xor.sv
module lfsr_tap_xor #(
  parameter int unsigned  WIDTH = 4,
  parameter logic [WIDTH-1:0] TAPS = '0
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb_lin
);
  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign chain[i+1] = chain[i] ^ state[i];
    end else begin : g_off
      assign chain[i+1] = chain[i];
    end
  end

  assign fb_lin = chain[WIDTH];
endmodule

// File: rtl/lfsr_zero_splice.sv
module lfsr_zero_splice #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] state,
  input  logic             fb_lin,
  output logic             upper_clear,
  output logic             near_zero,
  output logic             at_zero,
  output logic             fb_out
);
  // NOR of every bit except bit 0
  assign upper_clear = ~|state[WIDTH-1:1];
  assign near_zero   = upper_clear & state[0];
  assign at_zero     = upper_clear & ~state[0];
  assign fb_out      = fb_lin ^ upper_clear;
endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fb_in,
  output logic [WIDTH-1:0] state_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  state_q <= '1;
    else if (en) state_q <= {fb_in, state_q[WIDTH-1:1]};
  end
endmodule

// File: rtl/full_period_lfsr.sv
module full_period_lfsr #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] state_q
);
  import lfsr_pkg::*;

  localparam logic [63:0]      FULL_MASK = tap_mask(WIDTH);
  localparam logic [WIDTH-1:0] TAPS      = FULL_MASK[WIDTH-1:0];
  localparam logic [WIDTH-1:0] TOP_ONLY  = {1'b1, {(WIDTH-1){1'b0}}};

  logic fb_lin, fb_next, upper_clear, near_zero, at_zero;

  lfsr_tap_xor #(.WIDTH(WIDTH), .TAPS(TAPS)) u_taps (
    .state(state_q), .fb_lin(fb_lin)
  );

  lfsr_zero_splice #(.WIDTH(WIDTH)) u_splice (
    .state(state_q), .fb_lin(fb_lin), .upper_clear(upper_clear),
    .near_zero(near_zero), .at_zero(at_zero), .fb_out(fb_next)
  );

  lfsr_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_in(fb_next), .state_q(state_q)
  );

  // R1
  reset_ones_chk: assert property (@(posedge clk) !rst_n |=> state_q == '1);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(state_q));
  // R3
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> state_q[WIDTH-2:0] == $past(state_q[WIDTH-1:1]));
  // R5
  enter_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && near_zero) |=> state_q == '0);
  // R6
  leave_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && at_zero) |=> state_q == TOP_ONLY);
  // R7
  zero_only_spliced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !near_zero) |=> state_q != '0);
endmodule

// File: tb/full_period_lfsr_tb_top.sv
module full_period_lfsr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [3:0] q4;
  logic [7:0] q8;
  int m4, m8, total, passed;
  int seen4[16];
  int seen8[256];

  always #5 clk = ~clk;

  full_period_lfsr #(.WIDTH(4)) dut_i  (.clk(clk), .rst_n(rst_n), .en(en), .state_q(q4));
  full_period_lfsr #(.WIDTH(8)) dut8_i (.clk(clk), .rst_n(rst_n), .en(en), .state_q(q8));

  function automatic int nxt(input int s, input int w);
    int taps[$];
    int p;
    p = 0;
    if (w == 4) taps = {1, 0};
    else        taps = {4, 3, 2, 0};
    foreach (taps[k]) p ^= (s >> taps[k]) & 1;
    if ((s >> 1) == 0) p ^= 1;
    return (s >> 1) | (p << (w - 1));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic tick(input logic r, input logic e);
    rst_n = r;
    en    = e;
    if (!r) begin m4 = 15; m8 = 255; end
    else if (e) begin m4 = nxt(m4, 4); m8 = nxt(m8, 8); end
    @(posedge clk);
    #2;
    chk(int'(q4) == m4, "R3/R4 model w4", int'(q4), m4);
    chk(int'(q8) == m8, "R3/R4 model w8", int'(q8), m8);
  endtask

  initial begin
    automatic int seq8[16] = '{15, 7, 3, 1, 0, 8, 4, 2, 9, 12, 6, 11, 5, 10, 13, 14};
    automatic bit dup;
    m4 = 15; m8 = 255;
    // R1 and reset winning over enable
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    chk(q4 == 4'hF, "R1 reset w4", int'(q4), 15);
    chk(q8 == 8'hFF, "R1 reset w8", int'(q8), 255);

    // R8 / R7 full period from all ones
    seen4[15] = 1; seen8[255] = 1;
    dup = 1'b0;
    for (int n = 1; n <= 256; n++) begin
      tick(1'b1, 1'b1);
      if (n < 16) begin
        chk(int'(q4) == seq8[n], "R8 sequence", int'(q4), seq8[n]);
        seen4[q4]++;
      end
      if (n == 16) chk(q4 == 4'hF, "R7 period w4", int'(q4), 15);
      if (n < 256) seen8[q8]++;
    end
    chk(q8 == 8'hFF, "R7 period w8", int'(q8), 255);
    for (int s = 0; s < 16; s++) if (seen4[s] != 1) dup = 1'b1;
    chk(!dup, "R7 coverage w4", int'(dup), 0);
    dup = 1'b0;
    for (int s = 0; s < 256; s++) if (seen8[s] != 1) dup = 1'b1;
    chk(!dup, "R7 coverage w8", int'(dup), 0);

    // R2 alternating enable
    for (int n = 0; n < 40; n++) tick(1'b1, n[0] ^ n[2]);

    // R5 / R6 with enable held low at the splice points
    while (m4 != 1) tick(1'b1, 1'b1);
    for (int n = 0; n < 3; n++) begin
      tick(1'b1, 1'b0);
      chk(q4 == 4'h1, "R2 hold near-zero", int'(q4), 1);
    end
    tick(1'b1, 1'b1);
    chk(q4 == 4'h0, "R5 enter zero", int'(q4), 0);
    for (int n = 0; n < 2; n++) begin
      tick(1'b1, 1'b0);
      chk(q4 == 4'h0, "R2 hold zero", int'(q4), 0);
    end
    tick(1'b1, 1'b1);
    chk(q4 == 4'h8, "R6 leave zero", int'(q4), 8);

    // same on the 8-bit instance
    while (m8 != 1) tick(1'b1, 1'b1);
    tick(1'b1, 1'b1);
    chk(q8 == 8'h00, "R5 enter zero w8", int'(q8), 0);
    tick(1'b1, 1'b1);
    chk(q8 == 8'h80, "R6 leave zero w8", int'(q8), 128);

    // R1 reset mid-run with enable high
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    chk(q4 == 4'hF && q8 == 8'hFF, "R1 mid-run reset", int'(q4), 15);
    tick(1'b1, 1'b1);
    chk(q4 == 4'h7, "R4 first step", int'(q4), 7);

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule